// File: doc/BRIEF.md
# Read/Write Turnaround Spacing Checker

This block watches the command stream that a memory controller sends to a DDR-style DRAM. It tracks the minimum spacing that the data bus and each bank need between READ, WRITE and PRECHARGE commands. From that it produces one ready signal per command kind, with one per bank for PRECHARGE. A scheduler can use these to hold a command back until it is legal. When a command is issued while its ready signal is low, the block raises the matching violation flag for one cycle, so the same block also serves as a protocol monitor.

Each spacing rule has its own down-counter. A command loads a gap into every counter it affects. The gap is computed from the timing settings present in the cycle of issue: additive latency, read CAS latency, write CAS latency, tCCD, tWTR, tWR, tRTP and the burst mode. A ready output is high only when every counter that guards that command has reached zero. The burst mode matters only for writes. A write in fixed burst-chop-4 mode finishes its data two cycles sooner than a BL8 write or an on-the-fly chopped write, so the recovery windows that follow it start and end two cycles earlier.

Top module: `dram_spacing_chk`

## Requirements
- R1: After a READ issued in cycle n, a further READ is ready from cycle n+tCCD. After a WRITE issued in cycle n, a further WRITE is ready from cycle n+tCCD.
- R2: After a READ issued in cycle n, a WRITE is ready from cycle n+max(0, (AL+CL)+tCCD-(AL+CWL)+2).
- R3: With burst mode 2'b00 (fixed BL8), 2'b01 (on-the-fly) or 2'b11, a WRITE issued in cycle n holds off READ until cycle n+AL+CWL+4+tWTR.
- R4: With burst mode 2'b10 (fixed chop-4), both the WRITE-to-READ and the WRITE-to-PRECHARGE windows end two cycles earlier than in the other modes: n+AL+CWL+2+tWTR and n+AL+CWL+2+tWR.
- R5: With burst mode other than 2'b10, a WRITE issued in cycle n to bank b holds off PRECHARGE to bank b until cycle n+AL+CWL+4+tWR.
- R6: A READ issued in cycle n to bank b holds off PRECHARGE to bank b until cycle n+max(4, AL+tRTP).
- R7: The PRECHARGE windows are kept per bank: a READ or WRITE to one bank leaves pre_ready of every other bank unchanged.
- R8: A command issued in cycle n while its ready signal (pre_ready[cmd_bank] for PRECHARGE) is low raises the matching flag among rd_viol, wr_viol and pre_viol in cycle n+1 only. The command still opens its own windows.
- R9: When windows from several commands overlap, a ready signal stays low until the window that ends latest has closed.
- R10: After reset every ready output is high and every violation flag is low.
- R11: A cycle with cmd_valid low, or with cmd_op = 2'b00 (NOP), changes no window and raises no flag. The encodings are 2'b01 READ, 2'b10 WRITE and 2'b11 PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 00 NOP, 01 READ, 10 WRITE, 11 PRECHARGE |
| cmd_bank | input | BW | Target bank of the command |
| cfg_burst_mode | input | 2 | 00 BL8, 01 on-the-fly, 10 fixed chop-4, 11 treated as BL8 |
| cfg_al | input | TW | Additive latency, cycles |
| cfg_cl | input | TW | Read CAS latency, cycles |
| cfg_cwl | input | TW | Write CAS latency, cycles |
| cfg_tccd | input | TW | Column-to-column spacing, cycles |
| cfg_twtr | input | TW | Write-to-read recovery, cycles |
| cfg_twr | input | TW | Write recovery before precharge, cycles |
| cfg_trtp | input | TW | Read-to-precharge time, cycles |
| rd_ready | output | 1 | A READ may be issued this cycle |
| wr_ready | output | 1 | A WRITE may be issued this cycle |
| pre_ready | output | NB | Per bank: a PRECHARGE may be issued this cycle |
| rd_viol | output | 1 | A READ was issued while not ready in the previous cycle |
| wr_viol | output | 1 | A WRITE was issued while not ready in the previous cycle |
| pre_viol | output | 1 | A PRECHARGE was issued while not ready in the previous cycle |

## Verification
The bench targets the exact cycle in which each window closes. It issues the next command either one cycle early or exactly on time. An off-by-one in a counter load therefore appears as a spurious or a missing violation flag. A write in fixed chop-4 mode followed by a read or precharge shows whether the two-cycle shortening is applied, and only in that mode. An additive latency plus tRTP below four checks that the four-cycle floor holds. A chopped read-to-write gap that works out negative checks that it clamps to zero and does not wrap to a huge value. Overlapping writes followed by a read check that a later, shorter window never shortens an earlier, longer one. Precharges to untouched banks check that the windows do not leak between banks.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_PRE = 2'b11
  } op_e;

  localparam logic [1:0] BM_FIXED_CHOP = 2'b10;

  // Read-to-write bus gap: read latency plus tCCD plus two, less write latency.
  // Additive latency appears on both sides and cancels out.
  function automatic int rd2wr_gap(input int cl, input int tccd, input int cwl);
    int g;
    g = cl + tccd + 2 - cwl;
    return (g < 0) ? 0 : g;
  endfunction

  // Edge after the last write data beat, counted from the WRITE command.
  function automatic int wr_data_end(input int al, input int cwl, input bit chop_fixed);
    return al + cwl + (chop_fixed ? 2 : 4);
  endfunction

  // Read-to-precharge: tRTP counted from AL, never below four cycles.
  function automatic int rd2pre_gap(input int al, input int trtp);
    int g;
    g = al + trtp;
    return (g < 4) ? 4 : g;
  endfunction

endpackage

// File: rtl/dsc_gap_calc.sv
module dsc_gap_calc #(
  parameter int TW = 5,
  parameter int CW = TW + 3
) (
  input  logic [1:0]    burst_mode,
  input  logic [TW-1:0] al,
  input  logic [TW-1:0] cl,
  input  logic [TW-1:0] cwl,
  input  logic [TW-1:0] tccd,
  input  logic [TW-1:0] twtr,
  input  logic [TW-1:0] twr,
  input  logic [TW-1:0] trtp,
  output logic [CW-1:0] g_ccd,
  output logic [CW-1:0] g_rd2wr,
  output logic [CW-1:0] g_wr2rd,
  output logic [CW-1:0] g_wr2pre,
  output logic [CW-1:0] g_rd2pre
);
  import dsc_pkg::*;

  logic chop_fixed;
  int   wend;

  assign chop_fixed = (burst_mode == BM_FIXED_CHOP);

  always_comb begin
    wend     = wr_data_end(int'(al), int'(cwl), chop_fixed);
    g_ccd    = CW'(int'(tccd));
    g_rd2wr  = CW'(rd2wr_gap(int'(cl), int'(tccd), int'(cwl)));
    g_wr2rd  = CW'(wend + int'(twtr));
    g_wr2pre = CW'(wend + int'(twr));
    g_rd2pre = CW'(rd2pre_gap(int'(al), int'(trtp)));
  end

endmodule

// File: rtl/dsc_win_cnt.sv
module dsc_win_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] gap,
  output logic          idle
);
  logic [CW-1:0] cnt, dec, ld_val, nxt;

  always_comb begin
    dec    = (cnt == '0) ? '0 : cnt - CW'(1);
    ld_val = (gap == '0) ? '0 : gap - CW'(1);
    nxt    = (load && (ld_val > dec)) ? ld_val : dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  assign idle = (cnt == '0);

  // R9: an open window without new load shrinks by exactly one per cycle
  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  // R11: a closed window stays closed when nothing loads it
  p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && idle) |=> idle);

  // R9: a load never shortens a window that is still open
  p_no_shrink_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cnt > CW'(1)) |=> (cnt >= $past(cnt) - CW'(1)));

endmodule

// File: rtl/dsc_bank_guard.sv
module dsc_bank_guard #(
  parameter int NB = 8,
  parameter int CW = 8,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic          wr_go,
  input  logic [BW-1:0] bank,
  input  logic [CW-1:0] g_rd2pre,
  input  logic [CW-1:0] g_wr2pre,
  output logic [NB-1:0] pre_ready
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit, rtp_idle, wrec_idle;
    assign hit = (bank == BW'(b));

    dsc_win_cnt #(.CW(CW)) u_rtp (
      .clk(clk), .rst_n(rst_n), .load(rd_go && hit), .gap(g_rd2pre), .idle(rtp_idle));
    dsc_win_cnt #(.CW(CW)) u_wrec (
      .clk(clk), .rst_n(rst_n), .load(wr_go && hit), .gap(g_wr2pre), .idle(wrec_idle));

    assign pre_ready[b] = rtp_idle && wrec_idle;

    // R7: traffic to another bank leaves this bank's readiness alone
    p_bank_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_ready[b] && !((rd_go || wr_go) && hit)) |=> pre_ready[b]);
  end

endmodule

// File: rtl/dram_spacing_chk.sv
module dram_spacing_chk #(
  parameter int NB = 8,
  parameter int TW = 5,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int CW = TW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [BW-1:0] cmd_bank,
  input  logic [1:0]    cfg_burst_mode,
  input  logic [TW-1:0] cfg_al,
  input  logic [TW-1:0] cfg_cl,
  input  logic [TW-1:0] cfg_cwl,
  input  logic [TW-1:0] cfg_tccd,
  input  logic [TW-1:0] cfg_twtr,
  input  logic [TW-1:0] cfg_twr,
  input  logic [TW-1:0] cfg_trtp,
  output logic          rd_ready,
  output logic          wr_ready,
  output logic [NB-1:0] pre_ready,
  output logic          rd_viol,
  output logic          wr_viol,
  output logic          pre_viol
);
  import dsc_pkg::*;

  logic rd_go, wr_go, pre_go;
  logic [CW-1:0] g_ccd, g_rd2wr, g_wr2rd, g_wr2pre, g_rd2pre;
  logic rr_idle, ww_idle, rw_idle, wtr_idle;
  logic pre_hit_ready;

  assign rd_go  = cmd_valid && (cmd_op == OP_RD);
  assign wr_go  = cmd_valid && (cmd_op == OP_WR);
  assign pre_go = cmd_valid && (cmd_op == OP_PRE);

  dsc_gap_calc #(.TW(TW), .CW(CW)) u_gap (
    .burst_mode(cfg_burst_mode), .al(cfg_al), .cl(cfg_cl), .cwl(cfg_cwl),
    .tccd(cfg_tccd), .twtr(cfg_twtr), .twr(cfg_twr), .trtp(cfg_trtp),
    .g_ccd(g_ccd), .g_rd2wr(g_rd2wr), .g_wr2rd(g_wr2rd),
    .g_wr2pre(g_wr2pre), .g_rd2pre(g_rd2pre));

  dsc_win_cnt #(.CW(CW)) u_rd_rd (
    .clk(clk), .rst_n(rst_n), .load(rd_go), .gap(g_ccd), .idle(rr_idle));
  dsc_win_cnt #(.CW(CW)) u_wr_wr (
    .clk(clk), .rst_n(rst_n), .load(wr_go), .gap(g_ccd), .idle(ww_idle));
  dsc_win_cnt #(.CW(CW)) u_rd_wr (
    .clk(clk), .rst_n(rst_n), .load(rd_go), .gap(g_rd2wr), .idle(rw_idle));
  dsc_win_cnt #(.CW(CW)) u_wr_rd (
    .clk(clk), .rst_n(rst_n), .load(wr_go), .gap(g_wr2rd), .idle(wtr_idle));

  dsc_bank_guard #(.NB(NB), .CW(CW)) u_banks (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .wr_go(wr_go), .bank(cmd_bank),
    .g_rd2pre(g_rd2pre), .g_wr2pre(g_wr2pre), .pre_ready(pre_ready));

  assign rd_ready      = rr_idle && wtr_idle;
  assign wr_ready      = ww_idle && rw_idle;
  assign pre_hit_ready = pre_ready[cmd_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_viol  <= 1'b0;
      wr_viol  <= 1'b0;
      pre_viol <= 1'b0;
    end else begin
      rd_viol  <= rd_go  && !rd_ready;
      wr_viol  <= wr_go  && !wr_ready;
      pre_viol <= pre_go && !pre_hit_ready;
    end
  end

  // R1: a read with tCCD above one closes the read slot next cycle
  p_rd_blocks_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && cfg_tccd > TW'(1)) |=> !rd_ready);

  // R3: a write always closes the read slot for at least one cycle
  p_wr_blocks_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !rd_ready);

  // R5: a write closes precharge of its own bank
  p_wr_blocks_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !pre_ready[$past(cmd_bank)]);

  // R6: a read closes precharge of its own bank (floor of four cycles)
  p_rd_blocks_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !pre_ready[$past(cmd_bank)]);

  // R8: at most one flag, and only after a command of that kind
  p_viol_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_viol, wr_viol, pre_viol}));
  p_rd_viol_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_viol |-> $past(rd_go));

  // R10: everything open on leaving reset
  p_reset_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_ready && wr_ready && (&pre_ready)));

endmodule

// File: tb/tb_dram_spacing_chk.sv
module tb_dram_spacing_chk;
  localparam int NB = 8;
  localparam int TW = 5;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [BW-1:0] cmd_bank = '0;
  logic [1:0] cfg_burst_mode = 2'b00;
  logic [TW-1:0] cfg_al = '0, cfg_cl = 5'd5, cfg_cwl = 5'd5, cfg_tccd = 5'd4;
  logic [TW-1:0] cfg_twtr = 5'd4, cfg_twr = 5'd6, cfg_trtp = 5'd4;
  logic rd_ready, wr_ready, rd_viol, wr_viol, pre_viol;
  logic [NB-1:0] pre_ready;

  dram_spacing_chk #(.NB(NB), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cfg_burst_mode(cfg_burst_mode), .cfg_al(cfg_al),
    .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl), .cfg_tccd(cfg_tccd), .cfg_twtr(cfg_twtr),
    .cfg_twr(cfg_twr), .cfg_trtp(cfg_trtp), .rd_ready(rd_ready),
    .wr_ready(wr_ready), .pre_ready(pre_ready), .rd_viol(rd_viol),
    .wr_viol(wr_viol), .pre_viol(pre_viol));

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string tag = "R10";
  longint cur = 0;
  longint rd_allow = 0, wr_allow = 0;
  longint pre_allow [NB];
  bit e_rd_viol = 0, e_wr_viol = 0, e_pre_viol = 0;
  int c_al, c_cl, c_cwl, c_tccd, c_twtr, c_twr, c_trtp, c_mode;

  task automatic chk(input bit got, input bit exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", tag, what, cur, got, exp);
    end
  endtask

  function automatic longint lmax(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

  // Bench restatement of the windows from the requirement text
  function automatic int end_of_write();
    int wl;
    wl = c_al + c_cwl;
    if (c_mode == 2) return wl + 2;  // fixed chop-4
    return wl + 4;
  endfunction

  function automatic int read_to_write();
    int rl, wl, v;
    rl = c_al + c_cl;
    wl = c_al + c_cwl;
    v = rl + c_tccd - wl + 2;
    return (v > 0) ? v : 0;
  endfunction

  function automatic int read_to_pre();
    return (c_al + c_trtp > 4) ? c_al + c_trtp : 4;
  endfunction

  task automatic set_cfg(input int al, cl, cwl, tccd, twtr, twr, trtp, mode);
    c_al = al; c_cl = cl; c_cwl = cwl; c_tccd = tccd;
    c_twtr = twtr; c_twr = twr; c_trtp = trtp; c_mode = mode;
    cfg_al = TW'(al); cfg_cl = TW'(cl); cfg_cwl = TW'(cwl); cfg_tccd = TW'(tccd);
    cfg_twtr = TW'(twtr); cfg_twr = TW'(twr); cfg_trtp = TW'(trtp);
    cfg_burst_mode = 2'(mode);
  endtask

  // One cycle: check outputs at the falling edge, then present a command.
  task automatic step(input bit v, input int op, input int bank);
    int eff;
    chk(rd_ready, cur >= rd_allow, "rd_ready");
    chk(wr_ready, cur >= wr_allow, "wr_ready");
    for (int b = 0; b < NB; b++) chk(pre_ready[b], cur >= pre_allow[b], $sformatf("pre_ready[%0d]", b));
    chk(rd_viol, e_rd_viol, "rd_viol");
    chk(wr_viol, e_wr_viol, "wr_viol");
    chk(pre_viol, e_pre_viol, "pre_viol");
    eff = v ? op : 0;
    e_rd_viol  = (eff == 1) && (cur < rd_allow);
    e_wr_viol  = (eff == 2) && (cur < wr_allow);
    e_pre_viol = (eff == 3) && (cur < pre_allow[bank]);
    if (eff == 1) begin
      rd_allow = lmax(rd_allow, cur + c_tccd);
      wr_allow = lmax(wr_allow, cur + read_to_write());
      pre_allow[bank] = lmax(pre_allow[bank], cur + read_to_pre());
    end else if (eff == 2) begin
      wr_allow = lmax(wr_allow, cur + c_tccd);
      rd_allow = lmax(rd_allow, cur + end_of_write() + c_twtr);
      pre_allow[bank] = lmax(pre_allow[bank], cur + end_of_write() + c_twr);
    end
    cmd_valid = v;
    cmd_op = 2'(op);
    cmd_bank = BW'(bank);
    @(posedge clk);
    cur++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    int r, op, bank;
    void'($urandom(32'd4242));
    for (int b = 0; b < NB; b++) pre_allow[b] = 0;
    set_cfg(0, 5, 5, 4, 4, 6, 4, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur = 0;

    tag = "R10"; idle(2);

    // R1: read-read and write-write at tCCD, one early then on time
    tag = "R1"; step(1, 1, 0); idle(2); step(1, 1, 0); idle(3); step(1, 1, 0); idle(30);
    step(1, 2, 1); idle(3); step(1, 2, 1); idle(40);

    // R2: read then write, early and exact; then a clamped-to-zero gap
    tag = "R2"; set_cfg(0, 6, 5, 4, 4, 6, 4, 0);
    step(1, 1, 2); idle(5); step(1, 2, 2); idle(40);
    step(1, 1, 2); idle(6); step(1, 2, 2); idle(40);
    set_cfg(0, 2, 8, 1, 4, 6, 4, 0); step(1, 1, 3); step(1, 2, 3); idle(40);

    // R3: write then read in BL8 and on-the-fly mode
    tag = "R3"; set_cfg(2, 6, 5, 4, 3, 6, 4, 0);
    step(1, 2, 0); idle(12); step(1, 1, 0); idle(40);
    set_cfg(2, 6, 5, 4, 3, 6, 4, 1);
    step(1, 2, 0); idle(13); step(1, 1, 0); idle(40);

    // R4: fixed chop-4 shortens both write windows by two
    tag = "R4"; set_cfg(2, 6, 5, 4, 3, 6, 4, 2);
    step(1, 2, 4); idle(10); step(1, 1, 0); idle(40);
    step(1, 2, 4); idle(14); step(1, 3, 4); idle(40);

    // R5: write then precharge same bank
    tag = "R5"; set_cfg(0, 5, 5, 4, 4, 6, 4, 0);
    step(1, 2, 6); idle(14); step(1, 3, 6); idle(40);
    step(1, 2, 6); idle(15); step(1, 3, 6); idle(40);

    // R6: four-cycle floor and the AL+tRTP case
    tag = "R6"; set_cfg(0, 5, 5, 4, 4, 6, 2, 0);
    step(1, 1, 5); idle(2); step(1, 3, 5); idle(20);
    step(1, 1, 5); idle(3); step(1, 3, 5); idle(20);
    set_cfg(3, 5, 5, 4, 4, 6, 6, 0);
    step(1, 1, 5); idle(7); step(1, 3, 5); idle(20);
    step(1, 1, 5); idle(8); step(1, 3, 5); idle(20);

    // R7: other banks remain open
    tag = "R7"; step(1, 1, 2); step(1, 3, 5); step(1, 2, 1); step(1, 3, 7); idle(40);

    // R8: violating commands still open windows
    tag = "R8"; step(1, 2, 3); step(1, 2, 3); step(1, 1, 3); step(1, 3, 3); idle(50);

    // R9: overlapping windows, latest end wins
    tag = "R9"; set_cfg(0, 5, 5, 4, 8, 6, 4, 0);
    step(1, 2, 0); idle(3); set_cfg(0, 5, 5, 4, 2, 6, 4, 2); step(1, 2, 1); idle(30);

    // R11: NOP and invalid commands leave state untouched
    tag = "R11"; step(0, 1, 0); step(0, 2, 0); step(0, 3, 0); step(1, 0, 0);
    step(1, 1, 0); step(0, 1, 0); step(1, 0, 0); idle(20);

    // R9: constrained random mix
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      if (i % 300 == 0)
        set_cfg($urandom % 6, 5 + $urandom % 7, 5 + $urandom % 4, 4 + $urandom % 3,
                2 + $urandom % 5, 5 + $urandom % 8, 2 + $urandom % 7, $urandom % 4);
      r = $urandom % 8;
      bank = $urandom % NB;
      op = (r < 4) ? 0 : (r == 7) ? 1 : r - 3;
      if ($urandom % 4 != 0) begin
        if (op == 1 && cur < rd_allow) op = 0;
        if (op == 2 && cur < wr_allow) op = 0;
        if (op == 3 && cur < pre_allow[bank]) op = 0;
      end
      step((r == 7) ? 1'b0 : 1'b1, op, bank);
    end
    idle(40);
    finish_run();
  end

endmodule